// File: doc/BRIEF.md
# Overlapping 0101 Serial Pattern Detector

The block watches a one-bit serial stream and flags every place where the four most recent accepted bits, oldest first, read 0, 1, 0, 1. A bit is accepted on a rising clock edge only while its qualifier is high. Detection overlaps: the trailing "01" of one match can begin the next one, so the stream 010101 yields two detections.

Two state machines read the same accepted bits in parallel. The early flag comes from a four-state machine. Its output is a function of its state and the bit now on the input, so it rises during the cycle in which the completing bit is presented. The late flag comes from a five-state machine whose output depends only on its state. It rises in the cycle after the completing bit is accepted and holds until the next accepted bit. A consumer that wants the earliest possible reaction takes the early flag. One that needs a glitch-free registered flag takes the late one.

Top module: `serial_pat_det`

## Requirements
- R1: While `rst_i` is high, `hit_early_o` is 0 whatever the data inputs are. After any clock edge that samples `rst_i` high, `hit_late_o` is 0 and both machines restart with no accepted bits in their history.
- R2: `hit_early_o` is 1 exactly when `bit_vld_i` is 1, at least three bits have been accepted since reset, the last three accepted bits are 0, 1, 0 in arrival order, and `bit_i` is 1.
- R3: After each clock edge that accepts a bit, `hit_late_o` is 1 exactly when at least four bits have been accepted since reset and the last four, oldest first, are 0, 1, 0, 1.
- R4: Matches overlap. For 0,1,0,1,0,1 accepted after reset, `hit_early_o` is 1 while the 4th and 6th bits are presented, and `hit_late_o` is 1 after the 4th and 6th edges.
- R5: A cycle with `bit_vld_i` low leaves both machines unchanged, whatever the value of `bit_i`. In such a cycle `hit_early_o` is 0, and `hit_late_o` keeps its previous value after the edge.
- R6: `hit_late_o` after an accepting edge equals the value `hit_early_o` had in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; bits are sampled on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | High when `bit_i` carries a bit to accept |
| hit_early_o | output | 1 | Detect flag that depends on state and input (same cycle as the completing bit) |
| hit_late_o | output | 1 | Detect flag that depends on state only (one accepted bit later) |

## Verification
Three situations are the hardest to reach from the ports. The first is a reset taken while the early machine is one bit from a match and the completing bit is already on the input. The second is a run of qualifier-low cycles between the bits of a pattern, with the data line toggling during the gap. The third is the overlapping chain of matches. Every 8-bit stream is swept after a fresh reset, which covers all paths between the states, the overlap chains and the near-misses. Directed sequences then set up the reset-over-a-match case and put idle gaps with garbage data inside partial matches. All expected flags come from a model of the last four accepted bits.

// File: rtl/spd_pkg.sv
package spd_pkg;

    // Early machine: progress through the pattern
    typedef enum logic [1:0] {
        EA_IDLE = 2'd0,   // nothing useful seen
        EA_Z    = 2'd1,   // "0"
        EA_ZO   = 2'd2,   // "01"
        EA_ZOZ  = 2'd3    // "010"
    } early_st_e;

    // Late machine: adds a state that holds the detection
    typedef enum logic [2:0] {
        LA_IDLE = 3'd0,
        LA_Z    = 3'd1,
        LA_ZO   = 3'd2,
        LA_ZOZ  = 3'd3,
        LA_HIT  = 3'd4    // "0101" just completed
    } late_st_e;

    typedef struct packed {
        early_st_e st;
    } early_regs_t;

    typedef struct packed {
        late_st_e st;
    } late_regs_t;

endpackage

// File: rtl/spd_early_fsm.sv
module spd_early_fsm
    import spd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    input  logic vld_i,
    output logic hit_o
);
    early_regs_t r_q, r_d;

    always_comb begin
        r_d   = r_q;
        hit_o = 1'b0;
        if (vld_i && !rst_i) begin
            unique case (r_q.st)
                EA_IDLE: r_d.st = bit_i ? EA_IDLE : EA_Z;
                EA_Z:    r_d.st = bit_i ? EA_ZO   : EA_Z;
                EA_ZO:   r_d.st = bit_i ? EA_IDLE : EA_ZOZ;
                EA_ZOZ: begin
                    r_d.st = bit_i ? EA_ZO : EA_Z;
                    hit_o  = bit_i;
                end
                default: r_d.st = EA_IDLE;
            endcase
        end
        if (rst_i) r_d.st = EA_IDLE;
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    // R1
    early_rst_chk: assert property (@(posedge clk_i) rst_i |=> (r_q.st == EA_IDLE));
    // R5
    early_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> $stable(r_q.st));
    // R2
    early_hit_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> (r_q.st == EA_ZO));

endmodule

// File: rtl/spd_late_fsm.sv
module spd_late_fsm
    import spd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    input  logic vld_i,
    output logic hit_o
);
    late_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (vld_i) begin
            unique case (r_q.st)
                LA_IDLE: r_d.st = bit_i ? LA_IDLE : LA_Z;
                LA_Z:    r_d.st = bit_i ? LA_ZO   : LA_Z;
                LA_ZO:   r_d.st = bit_i ? LA_IDLE : LA_ZOZ;
                LA_ZOZ:  r_d.st = bit_i ? LA_HIT  : LA_Z;
                LA_HIT:  r_d.st = bit_i ? LA_IDLE : LA_ZOZ;
                default: r_d.st = LA_IDLE;
            endcase
        end
        if (rst_i) r_d.st = LA_IDLE;
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign hit_o = (r_q.st == LA_HIT);

    // R1
    late_rst_chk: assert property (@(posedge clk_i) rst_i |=> !hit_o);
    // R5
    late_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> $stable(hit_o));
    // R4
    late_no_repeat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_o && vld_i) |=> !hit_o);

endmodule

// File: rtl/serial_pat_det.sv
module serial_pat_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    input  logic bit_vld_i,
    output logic hit_early_o,
    output logic hit_late_o
);
    spd_early_fsm u_early (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .bit_i (bit_i),
        .vld_i (bit_vld_i),
        .hit_o (hit_early_o)
    );

    spd_late_fsm u_late (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .bit_i (bit_i),
        .vld_i (bit_vld_i),
        .hit_o (hit_late_o)
    );

    // R1
    always_comb begin
        if (rst_i === 1'b1) early_gate_chk: assert (hit_early_o == 1'b0);
    end
    // R6
    early_to_late_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld_i |=> (hit_late_o == $past(hit_early_o)));
    // R6
    late_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hit_late_o) |-> $past(hit_early_o));

endmodule

// File: tb/tb_serial_pat_det.sv
module tb_serial_pat_det;
    logic clk = 1'b0;
    logic rst, bit_in, vld;
    logic hit_e, hit_l;
    int checks = 0, fails = 0;
    logic [3:0] hist;
    int acc;
    logic prev_late;
    int early_count, late_count;

    always #10 clk = ~clk;  // 50 MHz

    serial_pat_det dut (
        .clk_i(clk), .rst_i(rst), .bit_i(bit_in), .bit_vld_i(vld),
        .hit_early_o(hit_e), .hit_late_o(hit_l)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic b, input logic v);
        @(negedge clk);
        rst = 1'b1; bit_in = b; vld = v;
        #2 chk("R1", hit_e, 1'b0);
        @(posedge clk); #1;
        chk("R1", hit_l, 1'b0);
        hist = 4'b0; acc = 0; prev_late = 1'b0;
        @(negedge clk); rst = 1'b0; vld = 1'b0;
    endtask

    task automatic step(input logic b, input logic v);
        logic exp_e, exp_l;
        @(negedge clk);
        bit_in = b; vld = v;
        exp_e = v && acc >= 3 && hist[2:0] == 3'b010 && b;
        #2;
        chk(v ? "R2" : "R5", hit_e, exp_e);
        if (hit_e) early_count++;
        @(posedge clk); #1;
        if (v) begin
            hist = {hist[2:0], b};
            acc++;
            exp_l = (acc >= 4) && (hist == 4'b0101);
            chk("R3", hit_l, exp_l);
            chk("R6", hit_l, exp_e);
        end else begin
            chk("R5", hit_l, prev_late);
        end
        if (hit_l && v) late_count++;
        prev_late = hit_l;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; bit_in = 1'b0; vld = 1'b0;
        hist = 4'b0; acc = 0; prev_late = 1'b0;
        @(posedge clk); #1;
        chk("R1", hit_l, 1'b0);
        do_reset(1'b0, 1'b0);

        // Exhaustive sweep of all 8-bit streams (R2, R3, R6)
        for (int n = 0; n < 256; n++) begin
            do_reset(1'b1, 1'b1);
            for (int i = 7; i >= 0; i--) step(n[i], 1'b1);
        end

        // R4: overlapping chain 010101
        do_reset(1'b0, 1'b0);
        early_count = 0; late_count = 0;
        step(0,1); step(1,1); step(0,1); step(1,1); step(0,1); step(1,1);
        chk("R4", early_count == 2, 1'b1);
        chk("R4", late_count == 2, 1'b1);

        // R5: idle gaps with toggling data inside partial matches
        do_reset(1'b0, 1'b0);
        step(0,1); step(1,0); step(0,0); step(1,1); step(1,0);
        step(0,1); step(1,0); step(0,0); step(1,0); step(1,1);
        step(1,0); step(0,0); step(1,0);
        step(0,1); step(1,1); step(0,0); step(1,0);

        // R1: reset while one bit from a match, completing bit presented
        do_reset(1'b0, 1'b0);
        step(0,1); step(1,1); step(0,1);
        do_reset(1'b1, 1'b1);
        step(1,1);
        step(0,1); step(1,1);
        // R1: reset while late flag is high
        step(0,1); step(1,1);
        chk("R3", hit_l, 1'b1);
        do_reset(1'b0, 1'b0);
        step(1,0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule